// File: doc/BRIEF.md
# Memory Access Ordering Classifier

The classifier sits in front of a data memory port and sorts each request before it reaches storage. A request carries an address, a byte count of 1, 2, 4 or 8, an operation class (data load, instruction fetch, atomic read-modify-write, or store) and three ordering flags: acquire, release, and reserve. The reserve flag means load-reserved on the read side and store-conditional on the write side. The block returns one of two results. The first is an access-kind code that tells memory which ordering and reservation semantics to apply. The second is an exception outcome, in which case no access is made.

Loads, fetches and atomics use the read-side flag table. Stores use the write-side table. Natural alignment is enforced only for accesses that carry ordering or reservation meaning. Plain accesses may be misaligned. Flag combinations that have no defined meaning are reported as not supported. A request is captured on `req_valid`, and its result appears on the following clock with `rsp_valid`. The result registers hold their value until the next accepted request.

Top module: `mem_order_classifier`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_outcome` and `rsp_kind` are 0. `rsp_valid` equals `req_valid` of the previous clock. The outcome and kind fields change only on a clock where `req_valid` was high, and otherwise hold.
- R2: For read-side operations (op 0 load, 1 fetch, 2 atomic) with a legal width and no alignment exception, the flags (acquire, release, reserve) map to kinds as follows: 000 gives 1 (plain), 100 gives 2 (acquire), 110 gives 3 (strong acquire), 001 gives 4 (reserved), 101 gives 5 (reserved acquire), 111 gives 6 (reserved strong acquire). Each of these has outcome 0 (ok).
- R3: A read-side request with release set and acquire clear (flags 010 or 011) gives outcome 6 (not supported) and kind 0.
- R4: For stores (op 3) with a legal width and no alignment exception, the flags map to kinds as follows: 000 gives 8 (plain), 010 gives 9 (release), 110 gives 10 (strong release), 001 gives 11 (conditional), 011 gives 12 (conditional release), 111 gives 13 (conditional strong release). Each of these has outcome 0.
- R5: A store with acquire set and release clear (flags 100 or 101) gives outcome 6 and kind 0.
- R6: A read-side request gives outcome 1 (load misaligned) exactly when acquire or reserve is set and the address is not a multiple of the width. Otherwise a misaligned address has no effect.
- R7: A store gives outcome 2 (store misaligned) exactly when release or conditional is set and the address is not a multiple of the width. Otherwise a misaligned address has no effect.
- R8: A width other than 1, 2, 4 or 8 gives an access fault whose code depends on the operation: fetch gives 3, load gives 4, and atomic or store gives 5.
- R9: Only one outcome is reported per request, chosen in this order: width fault, then alignment exception, then not supported. Whenever the outcome is nonzero, the kind is 0.
- R10: A 1-byte access is never reported as misaligned, whatever its address or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Access byte address |
| req_width | input | WIDTH_W | Access size in bytes |
| req_op | input | 2 | 0 load, 1 fetch, 2 atomic, 3 store |
| req_acq | input | 1 | Acquire ordering flag |
| req_rel | input | 1 | Release ordering flag |
| req_rsv | input | 1 | Reserve (read) or conditional (write) flag |
| rsp_valid | output | 1 | Result valid, one clock after the request |
| rsp_outcome | output | 3 | 0 ok, 1 load misaligned, 2 store misaligned, 3 fetch fault, 4 load fault, 5 store/atomic fault, 6 not supported |
| rsp_kind | output | 4 | Access-kind code, 0 when the outcome is nonzero |

## Verification
Several classification rules can apply to the same request. A misaligned address with reserve set and an undefined flag pattern (a read with 011, a store with 101) triggers both the alignment rule and the not-supported rule. An illegal width combined with ordering flags triggers both the width fault and the alignment rule. The bench sweeps every operation, flag pattern and width (legal and illegal) over aligned and unaligned addresses. This drives these overlaps on back-to-back clocks. A behavioural model picks the single winning outcome by the stated priority and compares it, together with a zero kind, against the registered output on every clock.

// File: rtl/mo_pkg.sv
package mo_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_FETCH = 2'd1,
        OP_AMO   = 2'd2,
        OP_STORE = 2'd3
    } mo_op_e;

    typedef enum logic [2:0] {
        OUT_OK          = 3'd0,
        OUT_MISALIGN_LD = 3'd1,
        OUT_MISALIGN_ST = 3'd2,
        OUT_FAULT_FETCH = 3'd3,
        OUT_FAULT_LOAD  = 3'd4,
        OUT_FAULT_STORE = 3'd5,
        OUT_UNSUPPORTED = 3'd6
    } mo_outcome_e;

    typedef enum logic [3:0] {
        KIND_NONE          = 4'd0,
        KIND_RD_PLAIN      = 4'd1,
        KIND_RD_ACQ        = 4'd2,
        KIND_RD_ACQ_STRONG = 4'd3,
        KIND_RD_RSV        = 4'd4,
        KIND_RD_RSV_ACQ    = 4'd5,
        KIND_RD_RSV_STRONG = 4'd6,
        KIND_WR_PLAIN      = 4'd8,
        KIND_WR_REL        = 4'd9,
        KIND_WR_REL_STRONG = 4'd10,
        KIND_WR_COND       = 4'd11,
        KIND_WR_COND_REL   = 4'd12,
        KIND_WR_COND_STRONG= 4'd13
    } mo_kind_e;

    typedef struct packed {
        logic acq;
        logic rel;
        logic rsv;
    } mo_flags_t;

    typedef struct packed {
        mo_outcome_e outcome;
        mo_kind_e    kind;
    } mo_result_t;

    function automatic mo_outcome_e fault_for_op(mo_op_e op);
        case (op)
            OP_FETCH: return OUT_FAULT_FETCH;
            OP_LOAD:  return OUT_FAULT_LOAD;
            default:  return OUT_FAULT_STORE;
        endcase
    endfunction

    function automatic logic needs_alignment(logic is_write, mo_flags_t f);
        return is_write ? (f.rel | f.rsv) : (f.acq | f.rsv);
    endfunction

endpackage

// File: rtl/mo_width_check.sv
module mo_width_check #(
    parameter int ADDR_W  = 32,
    parameter int WIDTH_W = 4,
    parameter int MAX_LG  = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WIDTH_W-1:0] width,
    output logic               legal,
    output logic               misaligned
);
    localparam int NSIZES = MAX_LG + 1;

    logic [NSIZES-1:0] size_hit;
    logic [NSIZES-1:0] size_off;

    for (genvar lg = 0; lg < NSIZES; lg++) begin : g_size
        localparam logic [ADDR_W-1:0]  LOW_MASK = ADDR_W'((64'd1 << lg) - 64'd1);
        localparam logic [WIDTH_W-1:0] BYTES    = WIDTH_W'(64'd1 << lg);
        assign size_hit[lg] = (width == BYTES);
        assign size_off[lg] = size_hit[lg] & (|(addr & LOW_MASK));
    end

    assign legal      = |size_hit;
    assign misaligned = |size_off;
endmodule

// File: rtl/mo_kind_decode.sv
module mo_kind_decode
    import mo_pkg::*;
(
    input  logic      is_write,
    input  mo_flags_t flags,
    output mo_kind_e  kind,
    output logic      supported
);
    always_comb begin
        kind      = KIND_NONE;
        supported = 1'b1;
        if (is_write) begin
            case ({flags.acq, flags.rel, flags.rsv})
                3'b000:  kind = KIND_WR_PLAIN;
                3'b010:  kind = KIND_WR_REL;
                3'b110:  kind = KIND_WR_REL_STRONG;
                3'b001:  kind = KIND_WR_COND;
                3'b011:  kind = KIND_WR_COND_REL;
                3'b111:  kind = KIND_WR_COND_STRONG;
                default: supported = 1'b0;
            endcase
        end else begin
            case ({flags.acq, flags.rel, flags.rsv})
                3'b000:  kind = KIND_RD_PLAIN;
                3'b100:  kind = KIND_RD_ACQ;
                3'b110:  kind = KIND_RD_ACQ_STRONG;
                3'b001:  kind = KIND_RD_RSV;
                3'b101:  kind = KIND_RD_RSV_ACQ;
                3'b111:  kind = KIND_RD_RSV_STRONG;
                default: supported = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mem_order_classifier.sv
module mem_order_classifier
    import mo_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WIDTH_W = 4,
    parameter int MAX_LG  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WIDTH_W-1:0] req_width,
    input  logic [1:0]         req_op,
    input  logic               req_acq,
    input  logic               req_rel,
    input  logic               req_rsv,
    output logic               rsp_valid,
    output logic [2:0]         rsp_outcome,
    output logic [3:0]         rsp_kind
);
    mo_op_e     op;
    mo_flags_t  flags;
    logic       is_write;
    logic       width_ok;
    logic       addr_off;
    mo_kind_e   dec_kind;
    logic       dec_ok;
    mo_result_t nxt;
    mo_result_t cur;

    assign op       = mo_op_e'(req_op);
    assign flags    = '{acq: req_acq, rel: req_rel, rsv: req_rsv};
    assign is_write = (op == OP_STORE);

    mo_width_check #(
        .ADDR_W (ADDR_W),
        .WIDTH_W(WIDTH_W),
        .MAX_LG (MAX_LG)
    ) u_width (
        .addr      (req_addr),
        .width     (req_width),
        .legal     (width_ok),
        .misaligned(addr_off)
    );

    mo_kind_decode u_kind (
        .is_write (is_write),
        .flags    (flags),
        .kind     (dec_kind),
        .supported(dec_ok)
    );

    always_comb begin
        nxt = '{outcome: OUT_OK, kind: KIND_NONE};
        if (!width_ok) begin
            nxt.outcome = fault_for_op(op);
        end else if (addr_off && needs_alignment(is_write, flags)) begin
            nxt.outcome = is_write ? OUT_MISALIGN_ST : OUT_MISALIGN_LD;
        end else if (!dec_ok) begin
            nxt.outcome = OUT_UNSUPPORTED;
        end else begin
            nxt.kind = dec_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            cur       <= '{outcome: OUT_OK, kind: KIND_NONE};
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                cur <= nxt;
            end
        end
    end

    assign rsp_outcome = cur.outcome;
    assign rsp_kind    = cur.kind;
endmodule

// File: rtl/mo_order_chk.sv
module mo_order_chk #(
    parameter int ADDR_W  = 32,
    parameter int WIDTH_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [WIDTH_W-1:0] req_width,
    input logic [1:0]         req_op,
    input logic               req_acq,
    input logic               req_rel,
    input logic               req_rsv,
    input logic               rsp_valid,
    input logic [2:0]         rsp_outcome,
    input logic [3:0]         rsp_kind
);
    logic [ADDR_W-1:0]  c_addr;
    logic [WIDTH_W-1:0] c_width;
    logic               c_store;
    logic               c_flagged;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_addr    <= '0;
            c_width   <= '0;
            c_store   <= 1'b0;
            c_flagged <= 1'b0;
        end else if (req_valid) begin
            c_addr    <= req_addr;
            c_width   <= req_width;
            c_store   <= (req_op == 2'd3);
            c_flagged <= req_acq | req_rel | req_rsv;
        end
    end

    logic c_legal;
    logic c_aligned;
    assign c_legal   = (c_width == WIDTH_W'(1)) || (c_width == WIDTH_W'(2)) ||
                       (c_width == WIDTH_W'(4)) || (c_width == WIDTH_W'(8));
    assign c_aligned = ((c_addr & ADDR_W'(c_width - WIDTH_W'(1))) == '0);

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    // R1
    payload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_outcome) && $stable(rsp_kind)));

    // R9
    exception_no_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_outcome != 3'd0) |-> rsp_kind == 4'd0);

    // R4
    ok_kind_side_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_outcome == 3'd0) |-> (rsp_kind != 4'd0 && rsp_kind[3] == c_store));

    // R8
    bad_width_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !c_legal) |-> (rsp_outcome >= 3'd3 && rsp_outcome <= 3'd5));

    // R6
    ordered_ok_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_outcome == 3'd0 && c_flagged && rsp_kind != 4'd1 && rsp_kind != 4'd8)
        |-> c_aligned);

    // R10
    byte_never_misaligned_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && c_width == WIDTH_W'(1)) |-> (rsp_outcome != 3'd1 && rsp_outcome != 3'd2));
endmodule

bind mem_order_classifier mo_order_chk #(
    .ADDR_W (ADDR_W),
    .WIDTH_W(WIDTH_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_width  (req_width),
    .req_op     (req_op),
    .req_acq    (req_acq),
    .req_rel    (req_rel),
    .req_rsv    (req_rsv),
    .rsp_valid  (rsp_valid),
    .rsp_outcome(rsp_outcome),
    .rsp_kind   (rsp_kind)
);

// File: tb/sim_mem_order_classifier.sv
module sim_mem_order_classifier;
    localparam int AW = 32;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [WW-1:0] req_width = '0;
    logic [1:0]    req_op = '0;
    logic          req_acq = 1'b0, req_rel = 1'b0, req_rsv = 1'b0;
    logic          rsp_valid;
    logic [2:0]    rsp_outcome;
    logic [3:0]    rsp_kind;

    always #4 clk = ~clk;

    mem_order_classifier #(.ADDR_W(AW), .WIDTH_W(WW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_width(req_width), .req_op(req_op), .req_acq(req_acq),
        .req_rel(req_rel), .req_rsv(req_rsv), .rsp_valid(rsp_valid),
        .rsp_outcome(rsp_outcome), .rsp_kind(rsp_kind)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    logic       exp_valid = 1'b0;
    logic [2:0] exp_out   = 3'd0;
    logic [3:0] exp_kind  = 4'd0;
    string      exp_tag   = "R1";

    // Behavioural reference from the requirements.
    task automatic model(input logic [AW-1:0] a, input int w, input int op,
                         input logic aq, input logic rl, input logic rs,
                         output logic [2:0] o, output logic [3:0] k, output string tag);
        bit rd, legal, mis, ordered;
        rd = (op != 3);
        legal = (w == 1) || (w == 2) || (w == 4) || (w == 8);
        ordered = rd ? (aq || rs) : (rl || rs);
        o = 3'd0; k = 4'd0;
        if (!legal) begin
            o = (op == 1) ? 3'd3 : (op == 0) ? 3'd4 : 3'd5;
            tag = ordered ? "R9" : "R8";
            return;
        end
        mis = (a % w) != 0;
        if (ordered && mis) begin
            o = rd ? 3'd1 : 3'd2;
            tag = rd ? "R6" : "R7";
            if (rd && !aq && rl) tag = "R9";
            if (!rd && aq && !rl) tag = "R9";
            return;
        end
        if (rd) begin
            tag = "R2";
            case ({aq, rl, rs})
                3'b000: k = 4'd1;
                3'b100: k = 4'd2;
                3'b110: k = 4'd3;
                3'b001: k = 4'd4;
                3'b101: k = 4'd5;
                3'b111: k = 4'd6;
                default: begin o = 3'd6; tag = "R3"; end
            endcase
        end else begin
            tag = "R4";
            case ({aq, rl, rs})
                3'b000: k = 4'd8;
                3'b010: k = 4'd9;
                3'b110: k = 4'd10;
                3'b001: k = 4'd11;
                3'b011: k = 4'd12;
                3'b111: k = 4'd13;
                default: begin o = 3'd6; tag = "R5"; end
            endcase
        end
        if (mis && o == 3'd0) tag = rd ? "R6" : "R7";
        if (w == 1 && ordered) tag = "R10";
    endtask

    task automatic compare();
        checks++;
        if (rsp_valid !== exp_valid || rsp_outcome !== exp_out || rsp_kind !== exp_kind) begin
            errors++;
            $display("FAIL %s: actual valid=%0b outcome=%0d kind=%0d expected valid=%0b outcome=%0d kind=%0d",
                     exp_tag, rsp_valid, rsp_outcome, rsp_kind, exp_valid, exp_out, exp_kind);
        end
    endtask

    task automatic step(input logic v, input logic [AW-1:0] a, input int w, input int op,
                        input logic aq, input logic rl, input logic rs);
        logic [2:0] o;
        logic [3:0] k;
        string      t;
        @(negedge clk);
        compare();
        req_valid = v; req_addr = a; req_width = WW'(w); req_op = 2'(op);
        req_acq = aq; req_rel = rl; req_rsv = rs;
        exp_valid = v;
        if (v) begin
            model(a, w, op, aq, rl, rs, o, k, t);
            exp_out = o; exp_kind = k; exp_tag = t;
        end else begin
            exp_tag = "R1";
        end
    endtask

    initial begin
        logic [AW-1:0] addrs [8];
        addrs = '{32'h0, 32'h1, 32'h2, 32'h4, 32'h6, 32'h8, 32'h13, 32'hFFFF_FFF8};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state observed on the first compare
        for (int op = 0; op < 4; op++) begin
            for (int f = 0; f < 8; f++) begin
                for (int w = 0; w < 16; w++) begin
                    for (int ai = 0; ai < 8; ai++) begin
                        step(1'b1, addrs[ai], w, op, f[2], f[1], f[0]);
                    end
                    // R1: idle cycle, payload must hold
                    if (w % 5 == 0) step(1'b0, 32'h3, 3, op, 1'b1, 1'b1, 1'b1);
                end
            end
        end
        step(1'b0, '0, 0, 0, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 0, 0, 1'b0, 1'b0, 1'b0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule